// File: doc/BRIEF.md
# Vault Request Queue Bank-Conflict Detector

This block holds the request queue of one memory vault and, every cycle, looks at the oldest few entries of that queue to find requests that target the same bank. Requests enter at the tail with a push strobe and leave from the head with a pop strobe, in strict first-in first-out order. Nothing is serviced inside the block: a pop stands in for the vault controller finishing the head request.

The inspection window covers the first `WIN` positions counted from the head. For each occupied position the bank number is taken from a fixed field of the request address. That field lies directly above the vault field, which lies above the byte offset within a block. Each position is compared with every older occupied position in the window. When an older match exists, the younger position is flagged, and the nearest older matching position is reported beside it. The detector only reads the queue: it never reorders, drops or edits an entry.

The results appear one clock after the queue state they describe, as a flag vector over window positions. They come with a summary event strobe, the device and vault identity of this queue, and the value of a free-running 64-bit cycle counter taken in the evaluation cycle.

Top module: `vault_conflict_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the queue is empty (`empty`=1, `full`=0), `eventValid`=0, `conflictVec`=0 and `evCycle`=0.
- R2: A push when not full appends `pushAddr` at the tail. A pop when not empty removes the head. A push while full is ignored, and so is a pop while empty. `headAddr` shows the oldest stored request whenever the queue is not empty.
- R3: The bank of a request is `addr[BANK_LSB +: BANK_W]` with `BANK_LSB = OFFSET_W + VAULT_W`. With the defaults this is bits [10:8]. Requests that differ only in other address bits share a bank.
- R4: Window position k (k=0 is the head) is flagged in `conflictVec[k]` when some occupied position i<k holds the same bank. Position 0 is never flagged, and a position whose bank is unique among older entries is not flagged.
- R5: Queue entries at position `WIN` or beyond are never compared, so a repeat bank that lies only outside the window raises no flag.
- R6: Slots that are not occupied (positions at or beyond the current count, including slots freed by a pop) take no part in any comparison.
- R7: For each flagged position k, `olderPos[k*POS_W +: POS_W]` holds the largest i<k whose bank matches. It is 0 for unflagged positions.
- R8: All event outputs are registered. They describe the queue state of the previous cycle. `evCycle` equals the cycle count of that evaluation cycle, and the counter starts at 0 at reset and rises by exactly one every cycle.
- R9: `eventValid` is 1 exactly when `conflictVec` is nonzero. While it is 1, `evDevice`=`DEV_ID` and `evVault`=`VAULT_ID`, and both are 0 otherwise.
- R10: Detection has no effect on the queue: requests leave in push order whether or not they conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Append `pushAddr` at the tail |
| pushAddr | input | ADDR_W | Request address to enqueue |
| popReq | input | 1 | Remove the head request |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| headAddr | output | ADDR_W | Address of the oldest entry |
| eventValid | output | 1 | At least one conflict flagged |
| conflictVec | output | WIN | Per-position conflict flags, bit 0 = head |
| olderPos | output | WIN*POS_W | Nearest older matching position per window position |
| evDevice | output | DEV_W | Device identity tag of the event |
| evVault | output | VAULT_W | Vault identity tag of the event |
| evCycle | output | 64 | Cycle count at evaluation |

## Verification
The assertions assume that reset is held for at least one clock before it is released, and that `pushValid` and `popReq` are free of unknowns while out of reset. They also assume the parameters give `WIN` between 2 and `DEPTH`. The stimulus drives every input on the falling edge, holds both strobes low during reset, and checks the block only after the queue has been idle for a full cycle, so that the registered flags match the queue contents the bench reference holds. The random bank patterns draw only small bank numbers, so repeated banks inside the window are frequent.

// File: rtl/vq_pkg.sv
package vq_pkg;
  localparam int CYCLE_W = 64;

  // strobes from control to datapath
  typedef struct packed {
    logic doPush;
    logic doPop;
  } strobe_t;
endpackage

// File: rtl/vq_ctrl.sv
module vq_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pushValid,
  input  logic                      popReq,
  output vq_pkg::strobe_t           stb,
  output logic [IDX_W-1:0]          headIdx,
  output logic [IDX_W-1:0]          tailIdx,
  output logic [CNT_W-1:0]          count,
  output logic                      full,
  output logic                      empty,
  output logic [vq_pkg::CYCLE_W-1:0] cycleCnt
);
  logic [IDX_W-1:0] headNext;
  logic [IDX_W-1:0] tailNext;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_comb begin
    stb.doPush = pushValid && !full;
    stb.doPop  = popReq && !empty;
  end

  assign headNext = (headIdx == IDX_W'(DEPTH - 1)) ? '0 : headIdx + 1'b1;
  assign tailNext = (tailIdx == IDX_W'(DEPTH - 1)) ? '0 : tailIdx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headIdx  <= '0;
      tailIdx  <= '0;
      count    <= '0;
      cycleCnt <= '0;
    end else begin
      cycleCnt <= cycleCnt + 1'b1;
      if (stb.doPush) tailIdx <= tailNext;
      if (stb.doPop)  headIdx <= headNext;
      case ({stb.doPush, stb.doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pushValid && !popReq) |=> (count == $past(count))); // R2

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && popReq && !pushValid) |=> empty); // R2

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cycleCnt == $past(cycleCnt) + 1'b1)); // R8
endmodule

// File: rtl/vq_datapath.sv
module vq_datapath #(
  parameter int DEPTH    = 8,
  parameter int WIN      = 4,
  parameter int ADDR_W   = 34,
  parameter int OFFSET_W = 4,
  parameter int VAULT_W  = 4,
  parameter int BANK_W   = 3,
  parameter int DEV_W    = 3,
  parameter int DEV_ID   = 1,
  parameter int VAULT_ID = 5,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int POS_W    = $clog2(WIN),
  localparam int BANK_LSB = OFFSET_W + VAULT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  vq_pkg::strobe_t            stb,
  input  logic [IDX_W-1:0]           headIdx,
  input  logic [IDX_W-1:0]           tailIdx,
  input  logic [CNT_W-1:0]           count,
  input  logic [vq_pkg::CYCLE_W-1:0] cycleCnt,
  input  logic [ADDR_W-1:0]          pushAddr,
  output logic [ADDR_W-1:0]          headAddr,
  output logic                       eventValid,
  output logic [WIN-1:0]             conflictVec,
  output logic [WIN*POS_W-1:0]       olderPos,
  output logic [DEV_W-1:0]           evDevice,
  output logic [VAULT_W-1:0]         evVault,
  output logic [vq_pkg::CYCLE_W-1:0] evCycle
);
  logic [DEPTH-1:0][ADDR_W-1:0] mem;
  logic [WIN-1:0]               winVld;
  logic [BANK_W-1:0]            winBank [WIN];
  logic [WIN-1:0]               flagC;
  logic [POS_W-1:0]             nearC   [WIN];
  logic [WIN*POS_W-1:0]         nearFlat;

  // storage: written only on a granted push
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (stb.doPush) begin
      mem[tailIdx] <= pushAddr;
    end
  end

  assign headAddr = mem[headIdx];

  // window extraction relative to the head
  for (genvar k = 0; k < WIN; k++) begin : g_win
    logic [IDX_W:0]   sum;
    logic [IDX_W-1:0] slot;
    assign sum  = {1'b0, headIdx} + (IDX_W + 1)'(k);
    assign slot = (sum >= (IDX_W + 1)'(DEPTH)) ? IDX_W'(sum - (IDX_W + 1)'(DEPTH))
                                                : sum[IDX_W-1:0];
    assign winVld[k]  = (CNT_W'(k) < count);
    assign winBank[k] = mem[slot][BANK_LSB +: BANK_W];
    assign nearFlat[k*POS_W +: POS_W] = nearC[k];
  end

  // pairwise compare: younger j against every older i
  always_comb begin
    for (int j = 0; j < WIN; j++) begin
      flagC[j] = 1'b0;
      nearC[j] = '0;
      for (int i = 0; i < j; i++) begin
        if (winVld[i] && winVld[j] && (winBank[i] == winBank[j])) begin
          flagC[j] = 1'b1;
          nearC[j] = POS_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conflictVec <= '0;
      olderPos    <= '0;
      eventValid  <= 1'b0;
      evDevice    <= '0;
      evVault     <= '0;
      evCycle     <= '0;
    end else begin
      conflictVec <= flagC;
      olderPos    <= nearFlat;
      eventValid  <= |flagC;
      evDevice    <= (|flagC) ? DEV_W'(DEV_ID) : '0;
      evVault     <= (|flagC) ? VAULT_W'(VAULT_ID) : '0;
      evCycle     <= cycleCnt;
    end
  end

  AST_HEAD_NEVER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !conflictVec[0]); // R4

  AST_FLAG_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (|conflictVec) |-> ($past(count) >= CNT_W'(2))); // R6

  AST_EVENT_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    eventValid |-> (conflictVec != '0)); // R9

  AST_QUEUE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.doPush |=> $stable(mem)); // R10

  for (genvar q = 1; q < WIN; q++) begin : g_chk
    AST_OLDER_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      conflictVec[q] |-> (olderPos[q*POS_W +: POS_W] < POS_W'(q))); // R7
    AST_FLAG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      conflictVec[q] |-> ($past(count) > CNT_W'(q))); // R6
  end
endmodule

// File: rtl/vault_conflict_top.sv
module vault_conflict_top #(
  parameter int DEPTH    = 8,
  parameter int WIN      = 4,
  parameter int ADDR_W   = 34,
  parameter int OFFSET_W = 4,
  parameter int VAULT_W  = 4,
  parameter int BANK_W   = 3,
  parameter int DEV_W    = 3,
  parameter int DEV_ID   = 1,
  parameter int VAULT_ID = 5,
  localparam int POS_W   = $clog2(WIN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pushValid,
  input  logic [ADDR_W-1:0]          pushAddr,
  input  logic                       popReq,
  output logic                       full,
  output logic                       empty,
  output logic [ADDR_W-1:0]          headAddr,
  output logic                       eventValid,
  output logic [WIN-1:0]             conflictVec,
  output logic [WIN*POS_W-1:0]       olderPos,
  output logic [DEV_W-1:0]           evDevice,
  output logic [VAULT_W-1:0]         evVault,
  output logic [vq_pkg::CYCLE_W-1:0] evCycle
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  vq_pkg::strobe_t            stb;
  logic [IDX_W-1:0]           headIdx;
  logic [IDX_W-1:0]           tailIdx;
  logic [CNT_W-1:0]           count;
  logic [vq_pkg::CYCLE_W-1:0] cycleCnt;

  vq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .popReq(popReq),
    .stb(stb), .headIdx(headIdx), .tailIdx(tailIdx), .count(count),
    .full(full), .empty(empty), .cycleCnt(cycleCnt)
  );

  vq_datapath #(
    .DEPTH(DEPTH), .WIN(WIN), .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W),
    .VAULT_W(VAULT_W), .BANK_W(BANK_W), .DEV_W(DEV_W),
    .DEV_ID(DEV_ID), .VAULT_ID(VAULT_ID)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .headIdx(headIdx), .tailIdx(tailIdx),
    .count(count), .cycleCnt(cycleCnt), .pushAddr(pushAddr), .headAddr(headAddr),
    .eventValid(eventValid), .conflictVec(conflictVec), .olderPos(olderPos),
    .evDevice(evDevice), .evVault(evVault), .evCycle(evCycle)
  );
endmodule

// File: tb/tb_vault_conflict_top.sv
module tb_vault_conflict_top;
  localparam int DEPTH = 8;
  localparam int WIN   = 4;
  localparam int AW    = 34;
  localparam int POS_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pushValid = 1'b0;
  logic [AW-1:0] pushAddr = '0;
  logic popReq = 1'b0;
  logic full, empty, eventValid;
  logic [AW-1:0] headAddr;
  logic [WIN-1:0] conflictVec;
  logic [WIN*POS_W-1:0] olderPos;
  logic [2:0] evDevice;
  logic [3:0] evVault;
  logic [63:0] evCycle;

  int total = 0;
  int bad = 0;
  longint benchCyc = 0;
  logic [AW-1:0] mq [DEPTH];
  int mCount = 0;

  vault_conflict_top dut (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .pushAddr(pushAddr),
    .popReq(popReq), .full(full), .empty(empty), .headAddr(headAddr),
    .eventValid(eventValid), .conflictVec(conflictVec), .olderPos(olderPos),
    .evDevice(evDevice), .evVault(evVault), .evCycle(evCycle)
  );

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) benchCyc <= benchCyc + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bank in bits [10:8], vault [7:4], offset [3:0], filler above
  function automatic logic [AW-1:0] mkAddr(input int bank, input int fill);
    logic [AW-1:0] a;
    a = '0;
    a[10:8] = 3'(bank);
    a[7:4]  = 4'(fill);
    a[3:0]  = 4'(fill * 3);
    a[20:11] = 10'(fill * 37);
    return a;
  endfunction

  task automatic pushOne(input logic [AW-1:0] a);
    @(negedge clk);
    pushValid = 1'b1;
    pushAddr  = a;
    @(negedge clk);
    pushValid = 1'b0;
    if (mCount < DEPTH) begin
      mq[mCount] = a;
      mCount++;
    end
  endtask

  task automatic popOne(input string req);
    @(negedge clk);
    if (mCount > 0) chk(req, longint'(headAddr), longint'(mq[0]));
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    if (mCount > 0) begin
      for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i + 1];
      mCount--;
    end
  endtask

  task automatic drain(input string req);
    while (mCount > 0) popOne(req);
  endtask

  // reference pairwise comparison over the modelled queue
  task automatic checkFlags(input string req);
    logic [WIN-1:0] ev;
    logic [WIN*POS_W-1:0] ep;
    ev = '0;
    ep = '0;
    @(posedge clk);
    @(negedge clk);
    for (int j = 1; j < WIN; j++)
      for (int i = 0; i < j; i++)
        if (j < mCount && mq[i][10:8] == mq[j][10:8]) begin
          ev[j] = 1'b1;
          ep[j*POS_W +: POS_W] = POS_W'(i);
        end
    chk({req, " R4 flags"}, longint'(conflictVec), longint'(ev));
    chk({req, " R7 older"}, longint'(olderPos), longint'(ep));
    chk({req, " R9 event"}, longint'(eventValid), longint'(ev != '0));
    chk({req, " R9 dev"}, longint'(evDevice), (ev != '0) ? 1 : 0);
    chk({req, " R9 vault"}, longint'(evVault), (ev != '0) ? 5 : 0);
    chk({req, " R8 cycle"}, longint'(evCycle), benchCyc - 1);
  endtask

  task automatic t_reset();
    chk("R1 empty", longint'(empty), 1);
    chk("R1 full", longint'(full), 0);
    chk("R1 event", longint'(eventValid), 0);
    chk("R1 vec", longint'(conflictVec), 0);
    chk("R1 cycle", longint'(evCycle), 0);
  endtask

  task automatic t_distinct();
    for (int b = 0; b < 4; b++) pushOne(mkAddr(b, b + 1));
    checkFlags("distinct");
    chk("R4 no flag distinct", longint'(conflictVec), 0);
    drain("R2 order distinct");
  endtask

  task automatic t_sameBankOtherBits();
    pushOne(mkAddr(3, 1));
    pushOne(mkAddr(5, 2));
    pushOne(mkAddr(3, 9));
    checkFlags("R3 field");
    chk("R3 pos2 flagged", longint'(conflictVec), 64'h4);
    chk("R7 pos2 older", longint'(olderPos[2*POS_W +: POS_W]), 0);
    drain("R2 order field");
  endtask

  task automatic t_triple();
    pushOne(mkAddr(6, 1));
    pushOne(mkAddr(6, 2));
    pushOne(mkAddr(1, 3));
    pushOne(mkAddr(6, 4));
    checkFlags("R7 triple");
    chk("R7 pos3 nearest", longint'(olderPos[3*POS_W +: POS_W]), 1);
    chk("R4 triple vec", longint'(conflictVec), 64'hA);
    drain("R10 order with conflicts");
  endtask

  task automatic t_window();
    for (int b = 0; b < 4; b++) pushOne(mkAddr(b, b));
    pushOne(mkAddr(0, 7));
    checkFlags("R5 window");
    chk("R5 outside window", longint'(conflictVec), 0);
    drain("R2 order window");
  endtask

  task automatic t_stale();
    pushOne(mkAddr(2, 1));
    pushOne(mkAddr(4, 2));
    pushOne(mkAddr(2, 3));
    checkFlags("R6 before pop");
    popOne("R2 head");
    checkFlags("R6 after pop");
    chk("R6 freed slot ignored", longint'(conflictVec), 0);
    drain("R2 order stale");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH + 1; i++) pushOne(mkAddr(i % 8, i + 1));
    chk("R2 full", longint'(full), 1);
    checkFlags("R2 full");
    drain("R2 order full");
    chk("R2 empty after drain", longint'(empty), 1);
  endtask

  task automatic t_popEmpty();
    popOne("R2 pop empty");
    chk("R2 still empty", longint'(empty), 1);
    pushOne(mkAddr(7, 2));
    @(negedge clk);
    chk("R2 head after empty pop", longint'(headAddr), longint'(mkAddr(7, 2)));
    drain("R2 order one");
  endtask

  task automatic t_cycleStep();
    longint c0;
    pushOne(mkAddr(1, 1));
    pushOne(mkAddr(1, 2));
    checkFlags("R8 stamp");
    c0 = longint'(evCycle);
    @(negedge clk);
    chk("R8 step one", longint'(evCycle), c0 + 1);
    drain("R2 order stamp");
  endtask

  task automatic t_random();
    for (int it = 0; it < 40; it++) begin
      int n;
      n = int'($urandom_range(0, DEPTH));
      for (int k = 0; k < n; k++) pushOne(mkAddr(int'($urandom_range(0, 3)), k + it));
      checkFlags("random");
      drain("R10 random order");
    end
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_distinct();
    t_sameBankOtherBits();
    t_triple();
    t_window();
    t_stale();
    t_full();
    t_popEmpty();
    t_cycleStep();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule